// File: doc/BRIEF.md
# Parallel EPROM Read-Cycle Controller

This block runs read cycles from a synchronous host onto a bank of byte-wide, 16K-word EPROM devices. The devices share an address bus, a data bus and a single active-low output-enable line. Each device has its own active-low chip-enable line. The host presents a 14-bit word address and a device index with a valid/ready handshake. The controller then drives the address and pulls low the chip enable of the chosen device only. It lowers the shared output enable late enough that the output-enable window ends exactly when the access time has elapsed. It samples the byte and returns it with a one-cycle valid strobe.

Every analog time is given in nanoseconds and converted to whole clock cycles. The conversion rounds up and uses the clock-period parameter. After each cycle the controller holds off the next request for the output-float time, so that the device just read has stopped driving the shared bus before another device is selected. When no cycle is running, all chip enables are high, which keeps every device in standby with its outputs floating.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it, every `mem_ce_n` bit is 1, `mem_oe_n` is 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. After that edge, `mem_addr` equals `req_addr`. The chip enable of the device whose binary index is `req_dev` is low (device i uses `mem_ce_n[i]`), every other chip enable is high, and `mem_oe_n` is still 1.
- R3: `mem_oe_n` goes low PRE cycles after the accepting edge and stays low for exactly OE cycles. PRE is ACC minus OE when that difference is positive and 0 otherwise. `mem_oe_n` is never low unless exactly one chip enable is low.
- R4: The byte on `mem_dq_in` is captured at the edge that comes PRE+OE cycles after the accepting edge, which is at least ACC cycles. `rsp_data` holds it while `rsp_valid` is 1, and `rsp_valid` lasts one cycle. On that same edge all chip enables and `mem_oe_n` return high.
- R5: After the capture edge, `req_ready` stays 0 for DF cycles, so the next chip enable can fall no sooner than DF+1 cycles after the output enable has risen.
- R6: While `req_ready` is 0, `req_valid`, `req_addr` and `req_dev` have no effect. The address and chip enables of the running cycle do not change, and exactly one response is produced.
- R7: At most one chip enable is low at any time. `mem_addr` does not change while a chip enable stays low.
- R8: ACC, OE and DF are the access, output-enable and float times in ns, each divided by `CLK_NS` and rounded up to a whole cycle count. With the defaults (250, 100, 85, 10) they are 25, 10 and 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W (14) | Word address to read |
| req_dev | input | SEL_W (2) | Binary index of the device to read |
| rsp_valid | output | 1 | One-cycle strobe marking `rsp_data` valid |
| rsp_data | output | DATA_W (8) | Captured byte |
| mem_addr | output | ADDR_W (14) | Shared address bus to the devices |
| mem_ce_n | output | NUM_DEV (4) | Per-device active-low chip enables |
| mem_oe_n | output | 1 | Shared active-low output enable |
| mem_dq_in | input | DATA_W (8) | Shared data bus from the devices |

## Verification
The bench builds the default configuration: four devices, a 10 ns clock and the 250/100/85 ns times. These give PRE=15, OE=10 and DF=9 cycles. The 85 ns float time does not divide evenly by the clock period, so it exercises the rounding. The bench sweeps every device index over a set of addresses that includes both address extremes and alternating bit patterns. For each read it measures the output-enable start, the output-enable length, the response cycle and the ready-return cycle against values it derives from the parameters. A behavioural responder returns correct data only when the chip enable has been low for the access time and the output enable for its delay, so a capture taken too early gives a wrong byte. On alternate reads the bench holds a conflicting request during the busy window to show that it is ignored.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_FLOAT  = 2'd3
  } rd_state_t;

  // Whole clock cycles covering a time in ns, rounded up.
  function automatic int cycles_for(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/eprom_wait_timer.sv
module eprom_wait_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // Terminal when this cycle is the limit-th since clear.
  assign last = (({1'b0, cnt_q} + (CNT_W+1)'(1)) == {1'b0, limit});

endmodule

// File: rtl/eprom_ce_decode.sv
module eprom_ce_decode #(
  parameter int NUM_DEV = 4,
  parameter int SEL_W   = 2
) (
  input  logic               en,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_DEV-1:0] ce_n
);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    assign ce_n[i] = !(en && (sel == SEL_W'(i)));
  end

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 10,
  parameter int T_ACC_NS = 250,
  parameter int T_OE_NS  = 100,
  parameter int T_DF_NS  = 85,
  localparam int SEL_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [SEL_W-1:0]   req_dev,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [NUM_DEV-1:0] mem_ce_n,
  output logic               mem_oe_n,
  input  logic [DATA_W-1:0]  mem_dq_in
);

  localparam int ACC_CYC = cycles_for(T_ACC_NS, CLK_NS);
  localparam int OE_RAW  = cycles_for(T_OE_NS, CLK_NS);
  localparam int OE_CYC  = (OE_RAW < 1) ? 1 : OE_RAW;
  localparam int DF_CYC  = cycles_for(T_DF_NS, CLK_NS);
  localparam int PRE_CYC = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
  localparam int MAX_CYC = (PRE_CYC > OE_CYC) ?
                           ((PRE_CYC > DF_CYC) ? PRE_CYC : DF_CYC) :
                           ((OE_CYC > DF_CYC) ? OE_CYC : DF_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  rd_state_t            state_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [NUM_DEV-1:0]   ce_n_q;
  logic                 oe_n_q;
  logic                 rsp_valid_q;
  logic [DATA_W-1:0]    rsp_data_q;

  logic                 accept;
  logic                 tmr_clear;
  logic                 tmr_last;
  logic [CNT_W-1:0]     tmr_limit;
  logic [NUM_DEV-1:0]   dec_ce_n;

  assign accept = (state_q == ST_IDLE) && req_valid;

  eprom_ce_decode #(
    .NUM_DEV (NUM_DEV),
    .SEL_W   (SEL_W)
  ) u_dec (
    .en   (1'b1),
    .sel  (req_dev),
    .ce_n (dec_ce_n)
  );

  always_comb begin
    case (state_q)
      ST_SETUP:  tmr_limit = CNT_W'(PRE_CYC);
      ST_STROBE: tmr_limit = CNT_W'(OE_CYC);
      ST_FLOAT:  tmr_limit = CNT_W'(DF_CYC);
      default:   tmr_limit = '0;
    endcase
  end

  assign tmr_clear = (state_q == ST_IDLE) || tmr_last;

  eprom_wait_timer #(
    .CNT_W (CNT_W)
  ) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clear),
    .limit (tmr_limit),
    .last  (tmr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      ce_n_q      <= '1;
      oe_n_q      <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q <= req_addr;
            ce_n_q <= dec_ce_n;
            if (PRE_CYC == 0) begin
              oe_n_q  <= 1'b0;
              state_q <= ST_STROBE;
            end else begin
              state_q <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          if (tmr_last) begin
            oe_n_q  <= 1'b0;
            state_q <= ST_STROBE;
          end
        end
        ST_STROBE: begin
          if (tmr_last) begin
            rsp_data_q  <= mem_dq_in;
            rsp_valid_q <= 1'b1;
            ce_n_q      <= '1;
            oe_n_q      <= 1'b1;
            state_q     <= (DF_CYC == 0) ? ST_IDLE : ST_FLOAT;
          end
        end
        default: begin
          if (tmr_last) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign mem_addr  = addr_q;
  assign mem_ce_n  = ce_n_q;
  assign mem_oe_n  = oe_n_q;

  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (&mem_ce_n && mem_oe_n));

  // R7
  ce_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_ce_n));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&mem_ce_n) && !(&$past(mem_ce_n))) |-> (mem_addr == $past(mem_addr)));

  // R3
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> ($countones(~mem_ce_n) == 1));

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R4
  release_at_capture_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> (&mem_ce_n && mem_oe_n && $past(!mem_oe_n)));

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  float_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (DF_CYC > 0 && rsp_valid) |-> !req_ready);

endmodule

// File: tb/tb_eprom_rd_ctrl.sv
`timescale 1ns/1ps
module tb_eprom_rd_ctrl;

  localparam int NDEV   = 4;
  localparam int AW     = 14;
  localparam int DW     = 8;
  localparam int CLKNS  = 10;
  localparam int TACC   = 250;
  localparam int TOE    = 100;
  localparam int TDF    = 85;
  // Expected counts, rounded up (R8)
  localparam int E_ACC  = (TACC + CLKNS - 1) / CLKNS;
  localparam int E_OE   = (TOE  + CLKNS - 1) / CLKNS;
  localparam int E_DF   = (TDF  + CLKNS - 1) / CLKNS;
  localparam int E_PRE  = (E_ACC > E_OE) ? E_ACC - E_OE : 0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_dev = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] mem_addr;
  logic [NDEV-1:0] mem_ce_n;
  logic          mem_oe_n;
  logic [DW-1:0] mem_dq_in = 8'hEE;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  eprom_rd_ctrl #(
    .NUM_DEV(NDEV), .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLKNS),
    .T_ACC_NS(TACC), .T_OE_NS(TOE), .T_DF_NS(TDF)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_dev(req_dev), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_dq_in(mem_dq_in)
  );

  function automatic logic [7:0] pattern(input int dev, input logic [AW-1:0] a);
    return a[7:0] ^ {a[13:8], 2'b00} ^ (8'h3C + 8'(dev * 17));
  endfunction

  // Behavioural device bank: valid data only after access and OE delays.
  realtime t_sel = 0.0;
  realtime t_oe  = 0.0;
  always @(mem_addr, mem_ce_n) t_sel = $realtime;
  always @(negedge mem_oe_n)   t_oe  = $realtime;

  initial begin
    #0.5;
    forever begin
      int sel_dev;
      sel_dev = -1;
      for (int i = 0; i < NDEV; i++) if (!mem_ce_n[i]) sel_dev = i;
      if (sel_dev >= 0 && !mem_oe_n &&
          ($realtime - t_sel) >= (TACC - 1) && ($realtime - t_oe) >= (TOE - 1))
        mem_dq_in = pattern(sel_dev, mem_addr);
      else
        mem_dq_in = 8'hEE;
      #1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_read(input int dev, input logic [AW-1:0] a, input bit poke);
    int oe_first, oe_cnt, rsp_at, rsp_cnt, rdy_at, got, guard;
    bit addr_ok, one_ok;
    oe_first = -1; oe_cnt = 0; rsp_at = -1; rsp_cnt = 0; rdy_at = -1; got = -1;
    addr_ok = 1; one_ok = 1; guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    req_valid = 1'b1; req_addr = a; req_dev = 2'(dev);
    @(negedge clk);
    // R2: address and single chip enable after accept, OE still high
    check(mem_addr == a && mem_ce_n == ~(NDEV'(1) << dev) && mem_oe_n,
          "R2 select", int'(mem_ce_n), int'(~(NDEV'(1) << dev) & 4'hF));
    if (poke) begin
      req_addr = ~a; req_dev = 2'(dev + 1);
    end else req_valid = 1'b0;
    for (int k = 1; k <= E_ACC + E_DF + 4; k++) begin
      if (k > 1) @(negedge clk);
      if (k == E_ACC - 2) req_valid = 1'b0;
      if ($countones(~mem_ce_n) > 1) one_ok = 0;
      if (!(&mem_ce_n) && mem_addr != a) addr_ok = 0;
      if (!mem_oe_n) begin
        if (oe_first < 0) oe_first = k;
        oe_cnt++;
      end
      if (rsp_valid) begin
        rsp_cnt++;
        if (rsp_at < 0) begin
          rsp_at = k; got = int'(rsp_data);
          check(&mem_ce_n && mem_oe_n, "R4 release", int'(mem_ce_n), 15);
        end
      end
      if (req_ready && rdy_at < 0) rdy_at = k;
    end
    check(oe_first == E_PRE + 1, "R3 oe start", oe_first, E_PRE + 1);
    check(oe_cnt == E_OE, "R3 oe length", oe_cnt, E_OE);
    check(rsp_at == E_PRE + E_OE + 1, "R4 R8 capture cycle", rsp_at, E_PRE + E_OE + 1);
    check(got == int'(pattern(dev, a)), "R4 data", got, int'(pattern(dev, a)));
    check(rdy_at == rsp_at + E_DF, "R5 R8 float guard", rdy_at, rsp_at + E_DF);
    check(rsp_cnt == 1, "R6 one response", rsp_cnt, 1);
    check(addr_ok, "R6 R7 address held", int'(mem_addr), int'(a));
    check(one_ok, "R7 single ce", 0, 1);
  endtask

  initial begin
    logic [AW-1:0] addrs [8];
    addrs[0] = 14'h0000; addrs[1] = 14'h3FFF; addrs[2] = 14'h2AAA; addrs[3] = 14'h1555;
    addrs[4] = 14'h0001; addrs[5] = 14'h2000; addrs[6] = 14'h00FF; addrs[7] = 14'h3F00;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(&mem_ce_n && mem_oe_n && !rsp_valid && req_ready, "R1 in reset",
          int'(mem_ce_n), 15);
    rst = 1'b0;
    @(negedge clk);
    check(&mem_ce_n && mem_oe_n && !rsp_valid && req_ready, "R1 after reset",
          int'(mem_ce_n), 15);
    for (int d = 0; d < NDEV; d++)
      for (int j = 0; j < 8; j++)
        do_read(d, addrs[j] ^ AW'(d * 33), (j % 2) == 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule